// File: doc/BRIEF.md
# Two-Level Shared Interrupt Controller

This block gathers event pulses from a storage-card host controller into a local interrupt status bank, filters them through a local enable mask, and folds the result into a small global bank. The global bank is shared with a sibling controller that presents its own summary request. One level-sensitive interrupt line leaves the block. Software reads and clears everything through a single-address register port.

Every local event is caught in a sticky status bit, whatever the state of its enable, so polling software can still see it. A status bit is cleared by writing a one to it. When an enabled local bit is set, the controller's own global bit is set. The global status bits are also write-one-to-clear. The shared line asserts only where a global status bit, its status-enable bit and its signal-enable bit are all set.

Top module: `shared_irq_ctrl`

## Requirements
- R1: An event pulse on `evt_pulse[i]` sets local status bit i at the next rising edge, whether or not local enable bit i is set. The implemented bits are 0 (card detect), 1 (status change), 2 (memory mode), 3 (I/O mode), 8 (true-IDE), 9 (PIO transfer error), 10 (buffer available) and 11 (transfer done). Bits 4 to 7 never set and always read 0.
- R2: A write to the local status register (address 0) clears every status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R3: If an event pulse and a clearing write hit the same local status bit in the same cycle, the bit is set after the edge.
- R4: The local enable register (address 1) stores one enable bit at the same position as each implemented status bit. Unimplemented positions read 0.
- R5: Global status bit 0 belongs to this controller. It sets at the edge after any local status bit is set while its enable bit is set. A set status bit whose enable is clear does not set it.
- R6: Global status bit 1 belongs to the sibling. It sets at the edge after `sib_req` is high. A write to the global status register (address 2) clears the bits written with 1, unless that bit's source is still active, in which case the bit stays set.
- R7: `irq` is high exactly when, for some bit g of the two global bits, global status g, global status-enable g (address 3) and global signal-enable g (address 4) are all 1.
- R8: After reset every register reads 0 and `irq` is low.
- R9: `reg_rdata` shows the register selected by `reg_addr` in the same cycle. Addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register select for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| evt_pulse | input | 12 | Local event pulses, one per status position |
| sib_req | input | 1 | Summary request from the sibling controller |
| irq | output | 1 | Shared level-sensitive interrupt line |

## Verification
A local status change shows on the read port one rising edge after the pulse or write that causes it. The controller's own global bit follows one edge later, because it is driven from the registered local status. `irq` follows the registered global state and enables with no further delay, so it is due in the same cycle that the global bit or an enable write becomes visible. The bench drives every stimulus on a falling edge and samples on the next falling edge, adding one idle cycle wherever the global path needs its extra edge. It sweeps all event positions, every pairing of enable bit and event bit, and all sixteen combinations of the two global enable registers.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int REG_ADDR_W = 3;

  localparam logic [REG_ADDR_W-1:0] ADDR_LSTS = 3'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_LEN  = 3'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_GSTS = 3'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_GSEN = 3'd3;
  localparam logic [REG_ADDR_W-1:0] ADDR_GSIG = 3'd4;

  // Sticky bit update: clear what is written, then let new events win.
  function automatic logic [31:0] sticky_next(input logic [31:0] cur,
                                              input logic [31:0] clr,
                                              input logic [31:0] set,
                                              input logic [31:0] keep);
    return ((cur & ~clr) | set) & keep;
  endfunction

  // Any position where all three vectors agree.
  function automatic logic any_triple(input logic [31:0] a,
                                      input logic [31:0] b,
                                      input logic [31:0] c);
    return |(a & b & c);
  endfunction

endpackage

// File: rtl/irqc_regport.sv
module irqc_regport
  import irqc_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int LOCAL_W  = 12,
  parameter int NUM_CTRL = 2
) (
  input  logic                  reg_wr,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic [LOCAL_W-1:0]    lsts,
  input  logic [LOCAL_W-1:0]    len,
  input  logic [NUM_CTRL-1:0]   gsts,
  input  logic [NUM_CTRL-1:0]   gsen,
  input  logic [NUM_CTRL-1:0]   gsig,
  output logic [LOCAL_W-1:0]    lsts_clr,
  output logic                  len_we,
  output logic [NUM_CTRL-1:0]   gsts_clr,
  output logic                  gsen_we,
  output logic                  gsig_we
);

  logic hit_lsts, hit_gsts;

  assign hit_lsts = reg_wr && (reg_addr == ADDR_LSTS);
  assign hit_gsts = reg_wr && (reg_addr == ADDR_GSTS);
  assign len_we   = reg_wr && (reg_addr == ADDR_LEN);
  assign gsen_we  = reg_wr && (reg_addr == ADDR_GSEN);
  assign gsig_we  = reg_wr && (reg_addr == ADDR_GSIG);

  assign lsts_clr = hit_lsts ? reg_wdata[LOCAL_W-1:0]  : '0;
  assign gsts_clr = hit_gsts ? reg_wdata[NUM_CTRL-1:0] : '0;

  always_comb begin
    case (reg_addr)
      ADDR_LSTS: reg_rdata = DATA_W'(lsts);
      ADDR_LEN:  reg_rdata = DATA_W'(len);
      ADDR_GSTS: reg_rdata = DATA_W'(gsts);
      ADDR_GSEN: reg_rdata = DATA_W'(gsen);
      ADDR_GSIG: reg_rdata = DATA_W'(gsig);
      default:   reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/irqc_local_bank.sv
module irqc_local_bank
  import irqc_pkg::*;
#(
  parameter int                 LOCAL_W = 12,
  parameter logic [LOCAL_W-1:0] VALID   = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LOCAL_W-1:0] evt,
  input  logic [LOCAL_W-1:0] sts_clr,
  input  logic               en_we,
  input  logic [LOCAL_W-1:0] en_wdata,
  output logic [LOCAL_W-1:0] sts,
  output logic [LOCAL_W-1:0] en,
  output logic               summary
);

  logic [LOCAL_W-1:0] set_hit;
  logic [LOCAL_W-1:0] clr_hit;
  logic [LOCAL_W-1:0] sts_n;
  logic [LOCAL_W-1:0] en_n;

  assign set_hit = evt & VALID;
  assign clr_hit = sts_clr & ~set_hit & VALID;
  assign sts_n   = LOCAL_W'(sticky_next(32'(sts), 32'(sts_clr),
                                        32'(evt), 32'(VALID)));
  assign en_n    = en_we ? (en_wdata & VALID) : en;
  assign summary = |(sts & en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts <= '0;
      en  <= '0;
    end else begin
      sts <= sts_n;
      en  <= en_n;
    end
  end

  AST_EVT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (set_hit != '0) |=> ((sts & $past(set_hit)) == $past(set_hit))); // R3

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_hit & sts) != '0) |=> ((sts & $past(clr_hit)) == '0)); // R2

  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr == '0 && set_hit == '0) |=> $stable(sts)); // R2

endmodule

// File: rtl/irqc_global_bank.sv
module irqc_global_bank
  import irqc_pkg::*;
#(
  parameter int NUM_CTRL = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CTRL-1:0] src,
  input  logic [NUM_CTRL-1:0] sts_clr,
  input  logic                sen_we,
  input  logic                sig_we,
  input  logic [NUM_CTRL-1:0] wdata,
  output logic [NUM_CTRL-1:0] sts,
  output logic [NUM_CTRL-1:0] sen,
  output logic [NUM_CTRL-1:0] sig,
  output logic                line
);

  for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sts[g] <= 1'b0;
        sen[g] <= 1'b0;
        sig[g] <= 1'b0;
      end else begin
        sts[g] <= (sts[g] & ~sts_clr[g]) | src[g];
        if (sen_we) sen[g] <= wdata[g];
        if (sig_we) sig[g] <= wdata[g];
      end
    end
  end

  assign line = any_triple(32'(sts), 32'(sen), 32'(sig));

  AST_GLB_SRC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (src != '0) |=> ((sts & $past(src)) == $past(src))); // R5

  AST_GLB_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0 && sts_clr == '0) |=> $stable(sts)); // R6

endmodule

// File: rtl/shared_irq_ctrl.sv
module shared_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int                 DATA_W    = 32,
  parameter int                 LOCAL_W   = 12,
  parameter int                 NUM_CTRL  = 2,
  parameter logic [LOCAL_W-1:0] EVT_VALID = 12'hF0F
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic [LOCAL_W-1:0]    evt_pulse,
  input  logic [NUM_CTRL-2:0]   sib_req,
  output logic                  irq
);

  logic [LOCAL_W-1:0]  lsts, len, lsts_clr;
  logic                len_we, local_summary;
  logic [NUM_CTRL-1:0] gsts, gsen, gsig, gsts_clr, gsrc;
  logic                gsen_we, gsig_we;

  irqc_regport #(
    .DATA_W(DATA_W), .LOCAL_W(LOCAL_W), .NUM_CTRL(NUM_CTRL)
  ) i_port (
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .lsts(lsts), .len(len), .gsts(gsts),
    .gsen(gsen), .gsig(gsig), .lsts_clr(lsts_clr), .len_we(len_we),
    .gsts_clr(gsts_clr), .gsen_we(gsen_we), .gsig_we(gsig_we)
  );

  irqc_local_bank #(
    .LOCAL_W(LOCAL_W), .VALID(EVT_VALID)
  ) i_local (
    .clk(clk), .rst_n(rst_n), .evt(evt_pulse), .sts_clr(lsts_clr),
    .en_we(len_we), .en_wdata(reg_wdata[LOCAL_W-1:0]),
    .sts(lsts), .en(len), .summary(local_summary)
  );

  assign gsrc = {sib_req, local_summary};

  irqc_global_bank #(
    .NUM_CTRL(NUM_CTRL)
  ) i_global (
    .clk(clk), .rst_n(rst_n), .src(gsrc), .sts_clr(gsts_clr),
    .sen_we(gsen_we), .sig_we(gsig_we), .wdata(reg_wdata[NUM_CTRL-1:0]),
    .sts(gsts), .sen(gsen), .sig(gsig), .line(irq)
  );

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (gsts != '0)); // R7

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (gsen == '0 || gsig == '0) |-> !irq); // R7

  AST_OWN_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((lsts & len) == '0 && gsts[0] == 1'b0) |=> !gsts[0]); // R5

endmodule

// File: tb/test_shared_irq_ctrl.sv
module test_shared_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [11:0] evt_pulse = '0;
  logic [0:0]  sib_req = '0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  shared_irq_ctrl i_shared_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
    .sib_req(sib_req), .irq(irq)
  );

  // Implemented positions: 0..3 and 8..11.
  function automatic bit implemented(int i);
    return (i < 4) || (i >= 8 && i < 12);
  endfunction

  function automatic logic [31:0] impl_mask();
    logic [31:0] m = '0;
    for (int i = 0; i < 12; i++) if (implemented(i)) m[i] = 1'b1;
    return m;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(logic [11:0] e);
    evt_pulse = e;
    tick();
    evt_pulse = '0;
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] bitv;
    logic        exp_irq;
    @(negedge clk);
    tick();
    rst_n = 1'b1;
    @(negedge clk);

    // R8: reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      check("R8 reset reg", v, 32'h0);
    end
    check("R8 reset irq", 32'(irq), 32'h0);

    // R1, R2: every event position, enables off
    for (int i = 0; i < 12; i++) begin
      bitv = 32'h1 << i;
      pulse(12'(bitv));
      rd(3'd0, v);
      check("R1 latch", v, implemented(i) ? bitv : 32'h0);
      wr(3'd0, ~bitv);
      rd(3'd0, v);
      check("R2 zero keeps", v, implemented(i) ? bitv : 32'h0);
      wr(3'd0, bitv);
      rd(3'd0, v);
      check("R2 one clears", v, 32'h0);
    end

    // R3: set wins over same-cycle clear
    for (int i = 0; i < 12; i++) begin
      if (!implemented(i)) continue;
      bitv = 32'h1 << i;
      pulse(12'(bitv));
      evt_pulse = 12'(bitv);
      wr(3'd0, bitv);
      evt_pulse = '0;
      rd(3'd0, v);
      check("R3 set wins", v, bitv);
      wr(3'd0, bitv);
    end

    // R4: enable storage
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, v);
    check("R4 enable mask", v, impl_mask());
    wr(3'd1, 32'h0);
    rd(3'd1, v);
    check("R4 enable clear", v, 32'h0);

    // R5: every enable position against every event position
    for (int k = 0; k < 12; k++) begin
      if (!implemented(k)) continue;
      wr(3'd1, 32'h1 << k);
      for (int j = 0; j < 12; j++) begin
        if (!implemented(j)) continue;
        pulse(12'(32'h1 << j));
        tick();
        rd(3'd2, v);
        check("R5 own global bit", v, (j == k) ? 32'h1 : 32'h0);
        wr(3'd0, 32'h1 << j);
        wr(3'd2, 32'h1);
        rd(3'd2, v);
        check("R5 own global cleared", v, 32'h0);
      end
    end
    wr(3'd1, 32'h0);

    // R6: sibling bit, clear while active, clear when idle
    sib_req = 1'b1;
    tick();
    rd(3'd2, v);
    check("R6 sibling sets", v, 32'h2);
    wr(3'd2, 32'h2);
    rd(3'd2, v);
    check("R6 clear while active", v, 32'h2);
    sib_req = 1'b0;
    wr(3'd2, 32'h2);
    rd(3'd2, v);
    check("R6 clear when idle", v, 32'h0);

    // R7: both global bits set, sweep both enable registers
    wr(3'd1, 32'h1);
    pulse(12'h001);
    sib_req = 1'b1;
    tick();
    rd(3'd2, v);
    check("R7 both global set", v, 32'h3);
    for (int se = 0; se < 4; se++) begin
      for (int sg = 0; sg < 4; sg++) begin
        wr(3'd3, 32'(se));
        wr(3'd4, 32'(sg));
        exp_irq = ((se & sg) != 0);
        check("R7 irq gating", 32'(irq), 32'(exp_irq));
      end
    end
    // R7: only sibling bit set, both enables full
    wr(3'd3, 32'h3);
    wr(3'd4, 32'h3);
    wr(3'd0, 32'h1);
    wr(3'd2, 32'h1);
    rd(3'd2, v);
    check("R7 own bit gone", v, 32'h2);
    check("R7 irq from sibling", 32'(irq), 32'h1);
    wr(3'd3, 32'h1);
    check("R7 sibling status-enable off", 32'(irq), 32'h0);
    sib_req = 1'b0;
    wr(3'd2, 32'h3);
    rd(3'd2, v);
    check("R7 all clear", v, 32'h0);
    check("R7 irq low", 32'(irq), 32'h0);

    // R9: readback and unused addresses
    rd(3'd3, v);
    check("R9 status-enable read", v, 32'h1);
    rd(3'd4, v);
    check("R9 signal-enable read", v, 32'h3);
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), v);
      check("R9 unused addr", v, 32'h0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule